// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write registers in an external Ethernet PHY over the two-wire serial management bus. The host supplies a one-cycle request strobe together with a read/write flag, a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a 4-bit clock-range code. The block then builds the management frame, shifts it out, and in a read collects the 16 bits that the PHY returns. The host sees a busy flag and, once busy has fallen after a read, the read value.

The serial clock is made by dividing the host clock with a fixed table of even ratios. It runs only while a frame is in flight. The pad side is split into a data output, an output enable and a data input, so the tri-state buffer lives in the pad ring. The output enable is dropped wherever the PHY owns the line.

The control is one state machine with these states: `S_IDLE`, `S_PRE` (32 one bits), `S_START` (2 bits), `S_OP` (2 bits), `S_PHY` (address of the PHY), `S_REG` (register address), `S_TA` (2 turnaround bits), `S_DATA` (16 bits) and `S_TAIL` (one released clock period). The transitions are as follows. `S_IDLE` goes to `S_PRE` on a request. After that, each state hands over to the next one in the order listed when its last bit period ends. `S_TAIL` returns to `S_IDLE` at the end of its single period.

Top module: `mdio_master`

## Requirements
- R1: The serial clock period, counted in host clock cycles, is 42, 62, 16, 26, 102 or 124 for range codes 0, 1, 2, 3, 4 and 5 respectively. The high phase is half of the period.
- R2: Any range code from 6 to 15 uses the ratio of code 0, which is 42.
- R3: After reset and whenever busy is low, mdc is low, mdo_oe is low and no clock pulses occur. After reset, rdata is zero.
- R4: At the first 32 rising edges of mdc, mdo is 1 with mdo_oe high. The next two rising edges carry 0 and then 1.
- R5: The next two bits are the opcode: 1,0 for a read (rd_wr=1) and 0,1 for a write. They are followed by phy_addr and then reg_addr, 5 bits each, most significant bit first. All of these bits are driven.
- R6: In a write, the turnaround bits are driven as 1 then 0. The 16 bits of wdata follow, most significant bit first, with mdo_oe high throughout.
- R7: In a read, mdo_oe is low from the first turnaround bit onwards. mdi is sampled at each of the 16 data rising edges, and the value is assembled with the most significant bit first. It appears on rdata when busy falls.
- R8: mdo and mdo_oe change only while mdc is low. They are updated one host cycle after the falling edge of mdc.
- R9: A frame is 64 clock periods plus one trailing period with mdo_oe low. Busy falls at the end of that trailing period, after exactly 65 rising edges of mdc.
- R10: A request raised while busy is high is ignored. The frame in progress keeps its fields, its ratio and its length.
- R11: A write frame leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| clk_sel | input | 4 | Clock-range code |
| rdata | output | 16 | Last read value |
| busy | output | 1 | Frame in flight |
| mdc | output | 1 | Serial management clock |
| mdo | output | 1 | Serial data towards the pad |
| mdo_oe | output | 1 | Pad output enable |
| mdi | input | 1 | Serial data from the pad |

## Verification
The assertions assume that the request fields, including clk_sel, are valid in the cycle in which start is accepted. They also assume that mdi is steady around each rising edge of mdc. The bench satisfies both assumptions. It changes request inputs only at falling host clock edges. Its PHY model changes mdi only right after a falling edge of mdc. A deliberate request raised mid-frame carries fields that differ from those of the active frame, so that any effect it had would be visible.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int SEL_W = 4;
    localparam int CNT_W = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_START,
        S_OP,
        S_PHY,
        S_REG,
        S_TA,
        S_DATA,
        S_TAIL
    } mdio_state_t;

    // Range code to host-clock cycles per serial clock period.
    function automatic logic [CNT_W-1:0] div_ratio(input logic [SEL_W-1:0] sel);
        logic [CNT_W-1:0] r;
        case (sel)
            4'd1:    r = 7'd62;
            4'd2:    r = 7'd16;
            4'd3:    r = 7'd26;
            4'd4:    r = 7'd102;
            4'd5:    r = 7'd124;
            default: r = 7'd42;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             drv_tick,
    output logic             smp_tick,
    output logic             end_tick
);

    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    assign ratio = div_ratio(sel);
    assign half  = ratio >> 1;

    always_comb begin
        if (!run)
            cnt_nxt = '0;
        else if (cnt == ratio - 1'b1)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            mdc <= run && (cnt_nxt >= half);
        end
    end

    // Period start (mdc already low), cycle before rise, last cycle.
    assign drv_tick = run && (cnt == '0);
    assign smp_tick = run && (cnt == half - 1'b1);
    assign end_tick = run && (cnt == ratio - 1'b1);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ratio); // R1

    AST_MDC_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        drv_tick |-> !mdc); // R8

endmodule

// File: rtl/mdio_txrx.sv
module mdio_txrx #(
    parameter int PAY_W  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAY_W-1:0]  load_word,
    input  logic              shift,
    input  logic              capture,
    input  logic              commit,
    input  logic              mdi,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rdata
);

    logic [PAY_W-1:0]  tx_sh;
    logic [DATA_W-1:0] rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= load_word;
        else if (shift)
            tx_sh <= {tx_sh[PAY_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (capture)
            rx_sh <= {rx_sh[DATA_W-2:0], mdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (commit)
            rdata <= rx_sh;
    end

    assign tx_bit = tx_sh[PAY_W-1];

    AST_NO_LOAD_AND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R10

    AST_RDATA_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> $stable(rdata)); // R11

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_wr,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  clk_sel,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              mdc,
    output logic              mdo,
    output logic              mdo_oe,
    input  logic              mdi
);

    localparam int PAY_W = 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
    localparam int MAX_A = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int MAX_B = (PHY_W > REG_W) ? PHY_W : REG_W;
    localparam int MAXF  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int FC_W  = $clog2(MAXF);

    mdio_state_t       state;
    mdio_state_t       state_nxt;
    logic [FC_W-1:0]   fcnt;
    logic [FC_W-1:0]   fcnt_nxt;
    logic              req_read;
    logic [SEL_W-1:0]  sel_q;
    logic              accept;
    logic              drv_tick;
    logic              smp_tick;
    logic              end_tick;
    logic              tx_bit;
    logic              cur_bit;
    logic              cur_oe;
    logic              shift_en;
    logic              capture_en;
    logic              commit_en;
    logic [PAY_W-1:0]  load_word;

    // Bits in the field a state sends, used when entering it.
    function automatic logic [FC_W-1:0] last_idx(input mdio_state_t s);
        int n;
        unique case (s)
            S_PRE:   n = PRE_LEN;
            S_PHY:   n = PHY_W;
            S_REG:   n = REG_W;
            S_DATA:  n = DATA_W;
            S_START,
            S_OP,
            S_TA:    n = 2;
            S_TAIL,
            S_IDLE:  n = 1;
            default: n = 1;
        endcase
        return FC_W'(n - 1);
    endfunction

    assign accept = (state == S_IDLE) && start;
    assign busy   = (state != S_IDLE);

    assign load_word = {2'b01, (rd_wr ? 2'b10 : 2'b01), phy_addr, reg_addr, 2'b10, wdata};

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_read <= 1'b0;
            sel_q    <= '0;
        end else if (accept) begin
            req_read <= rd_wr;
            sel_q    <= clk_sel;
        end
    end

    mdio_clkdiv u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .sel      (sel_q),
        .mdc      (mdc),
        .drv_tick (drv_tick),
        .smp_tick (smp_tick),
        .end_tick (end_tick)
    );

    // Next-state logic: each field advances when its last bit period ends.
    always_comb begin
        state_nxt = state;
        fcnt_nxt  = fcnt;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_nxt = S_PRE;
                    fcnt_nxt  = last_idx(S_PRE);
                end
            end
            S_PRE, S_START, S_OP, S_PHY, S_REG, S_TA, S_DATA, S_TAIL: begin
                if (end_tick) begin
                    if (fcnt != '0) begin
                        fcnt_nxt = fcnt - 1'b1;
                    end else begin
                        unique case (state)
                            S_PRE:   state_nxt = S_START;
                            S_START: state_nxt = S_OP;
                            S_OP:    state_nxt = S_PHY;
                            S_PHY:   state_nxt = S_REG;
                            S_REG:   state_nxt = S_TA;
                            S_TA:    state_nxt = S_DATA;
                            S_DATA:  state_nxt = S_TAIL;
                            default: state_nxt = S_IDLE;
                        endcase
                        fcnt_nxt = last_idx(state_nxt);
                    end
                end
            end
            default: begin
                state_nxt = S_IDLE;
                fcnt_nxt  = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            fcnt  <= '0;
        end else begin
            state <= state_nxt;
            fcnt  <= fcnt_nxt;
        end
    end

    // Per-state bit and drive decision
    always_comb begin
        cur_bit = 1'b0;
        cur_oe  = 1'b0;
        unique case (state)
            S_PRE: begin
                cur_bit = 1'b1;
                cur_oe  = 1'b1;
            end
            S_START, S_OP, S_PHY, S_REG: begin
                cur_bit = tx_bit;
                cur_oe  = 1'b1;
            end
            S_TA, S_DATA: begin
                cur_bit = req_read ? 1'b0 : tx_bit;
                cur_oe  = !req_read;
            end
            S_IDLE, S_TAIL: begin
                cur_bit = 1'b0;
                cur_oe  = 1'b0;
            end
            default: begin
                cur_bit = 1'b0;
                cur_oe  = 1'b0;
            end
        endcase
    end

    // Output register: pins move one cycle after mdc falls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdo    <= 1'b0;
            mdo_oe <= 1'b0;
        end else if (state == S_IDLE) begin
            mdo    <= 1'b0;
            mdo_oe <= 1'b0;
        end else if (drv_tick) begin
            mdo    <= cur_bit;
            mdo_oe <= cur_oe;
        end
    end

    assign shift_en   = end_tick && (state inside {S_START, S_OP, S_PHY, S_REG, S_TA, S_DATA});
    assign capture_en = smp_tick && (state == S_DATA) && req_read;
    assign commit_en  = end_tick && (state == S_TAIL) && req_read;

    mdio_txrx #(
        .PAY_W  (PAY_W),
        .DATA_W (DATA_W)
    ) u_txrx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (load_word),
        .shift     (shift_en),
        .capture   (capture_en),
        .commit    (commit_en),
        .mdi       (mdi),
        .tx_bit    (tx_bit),
        .rdata     (rdata)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdo_oe && !mdc)); // R3

    AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> busy); // R3

    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE && drv_tick) |=> (mdo_oe && mdo)); // R4

    AST_WRITE_TA_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TA && !req_read && fcnt == 1 && drv_tick) |=> (mdo_oe && mdo)); // R6

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_TA || state == S_DATA) && req_read && drv_tick) |=> !mdo_oe); // R7

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdo_oe))); // R8

    AST_TAIL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TAIL && drv_tick) |=> !mdo_oe); // R9

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state != S_TAIL) |=> busy); // R10

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  clk_sel = '0;
    logic        mdi = 1'b1;
    logic [15:0] rdata;
    logic        busy;
    logic        mdc;
    logic        mdo;
    logic        mdo_oe;

    always #5 clk = ~clk;

    mdio_master u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_wr    (rd_wr),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .clk_sel  (clk_sel),
        .rdata    (rdata),
        .busy     (busy),
        .mdc      (mdc),
        .mdo      (mdo),
        .mdo_oe   (mdo_oe),
        .mdi      (mdi)
    );

    int checks = 0;
    int fails  = 0;

    // Pin monitor and PHY model
    int          cyc = 0;
    int          rise_cnt = 0;
    int          t_rise0 = 0;
    int          t_rise1 = 0;
    int          t_fall0 = 0;
    int          hold_viol = 0;
    logic        mdc_prev = 1'b0;
    logic        mdo_prev = 1'b0;
    logic        oe_prev = 1'b0;
    logic [64:0] mdo_rec = '0;
    logic [64:0] oe_rec = '0;
    logic [15:0] phy_rval = '0;
    logic [15:0] last_rd = '0;

    function automatic logic phy_bit(input int idx, input logic [15:0] v);
        if (idx == 47)
            return 1'b0;
        if (idx >= 48 && idx <= 63)
            return v[63 - idx];
        return 1'b1;
    endfunction

    function automatic int exp_div(input logic [3:0] sel);
        case (sel)
            4'd1:    return 62;
            4'd2:    return 16;
            4'd3:    return 26;
            4'd4:    return 102;
            4'd5:    return 124;
            default: return 42;
        endcase
    endfunction

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mdc && mdc_prev && (mdo !== mdo_prev || mdo_oe !== oe_prev))
            hold_viol = hold_viol + 1;
        if (mdc && !mdc_prev) begin
            if (rise_cnt <= 64) begin
                mdo_rec[rise_cnt] = mdo;
                oe_rec[rise_cnt]  = mdo_oe;
            end
            if (rise_cnt == 0) t_rise0 = cyc;
            if (rise_cnt == 1) t_rise1 = cyc;
            rise_cnt = rise_cnt + 1;
        end
        if (!mdc && mdc_prev) begin
            if (rise_cnt == 1) t_fall0 = cyc;
            mdi = phy_bit(rise_cnt, phy_rval);
        end
        mdc_prev = mdc;
        mdo_prev = mdo;
        oe_prev  = mdo_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic rw, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [3:0] sel,
                           input logic [15:0] rv, input bit poke);
        logic [63:0] fr;
        logic [63:0] got;
        logic [63:0] goe;
        int div;
        int waitc;
        fr  = {32'hFFFF_FFFF, 2'b01, (rw ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
        div = exp_div(sel);
        phy_rval  = rv;
        rise_cnt  = 0;
        hold_viol = 0;
        mdo_rec   = '0;
        oe_rec    = '0;
        mdi       = 1'b1;
        @(negedge clk);
        rd_wr = rw; phy_addr = pa; reg_addr = ra; wdata = wd; clk_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20 * div) @(negedge clk);
            rd_wr = ~rw; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
            clk_sel = (sel == 4'd2) ? 4'd3 : 4'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waitc = 0;
        while (busy && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        repeat (2 * div) @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            got[63 - i] = mdo_rec[i];
            goe[63 - i] = oe_rec[i];
        end
        chk(rise_cnt == 65, poke ? "R10 edge count with mid-frame request" : "R9 rising edges per frame",
            64'(rise_cnt), 64'd65);
        chk(oe_rec[64] == 1'b0, "R9 trailing period released", 64'(oe_rec[64]), 64'd0);
        chk(!mdc && !mdo_oe && !busy, "R3 quiet after frame", {61'd0, mdc, mdo_oe, busy}, 64'd0);
        chk((t_rise1 - t_rise0) == div, (sel > 4'd5) ? "R2 reserved code period" : "R1 clock period",
            64'(t_rise1 - t_rise0), 64'(div));
        chk((t_fall0 - t_rise0) == div / 2, "R1 high phase", 64'(t_fall0 - t_rise0), 64'(div / 2));
        chk(got[63:30] == fr[63:30] && goe[63:30] == '1, "R4 preamble and start",
            64'(got[63:30]), 64'(fr[63:30]));
        chk(got[29:18] == fr[29:18] && goe[29:18] == '1,
            poke ? "R10 fields unchanged by mid-frame request" : "R5 opcode and addresses",
            64'(got[29:18]), 64'(fr[29:18]));
        chk(hold_viol == 0, "R8 pins steady while mdc high", 64'(hold_viol), 64'd0);
        if (rw) begin
            last_rd = rv;
            chk(goe[17:0] == '0, "R7 line released for turnaround and data", 64'(goe[17:0]), 64'd0);
            chk(rdata == rv, "R7 read value", 64'(rdata), 64'(rv));
        end else begin
            chk(got[17:0] == fr[17:0] && goe[17:0] == '1, "R6 turnaround and write data",
                64'(got[17:0]), 64'(fr[17:0]));
            chk(rdata == last_rd, "R11 rdata kept across write", 64'(rdata), 64'(last_rd));
        end
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] rsel;
        int seed_set;
        seed_set = $urandom(32'd7031);
        repeat (4) @(negedge clk);
        chk(!busy && !mdc && !mdo_oe && rdata == 16'h0, "R3 reset state",
            {44'd0, rdata, 1'b0, busy, mdc, mdo_oe}, 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!busy && !mdc && !mdo_oe, "R3 idle after reset release", {61'd0, busy, mdc, mdo_oe}, 64'd0);

        // Directed corners
        run_txn(1'b0, 5'h1F, 5'h00, 16'hA55A, 4'd2, 16'h0000, 1'b0);
        run_txn(1'b1, 5'h00, 5'h1F, 16'h0000, 4'd3, 16'h8001, 1'b0);
        run_txn(1'b0, 5'h15, 5'h0A, 16'hFFFF, 4'd0, 16'h0000, 1'b0);  // R11
        run_txn(1'b1, 5'h0A, 5'h15, 16'h0000, 4'd1, 16'h7FFE, 1'b0);
        run_txn(1'b0, 5'h03, 5'h1C, 16'h0001, 4'd4, 16'h0000, 1'b0);
        run_txn(1'b1, 5'h11, 5'h02, 16'h0000, 4'd5, 16'h1234, 1'b0);
        run_txn(1'b1, 5'h07, 5'h07, 16'h0000, 4'd6, 16'hBEEF, 1'b0);  // R2
        run_txn(1'b0, 5'h08, 5'h10, 16'h8000, 4'd7, 16'h0000, 1'b0);  // R2
        run_txn(1'b0, 5'h19, 5'h06, 16'h3C3C, 4'd15, 16'h0000, 1'b0); // R2
        run_txn(1'b1, 5'h0C, 5'h13, 16'h0000, 4'd2, 16'hC0DE, 1'b1);  // R10
        run_txn(1'b0, 5'h1A, 5'h05, 16'h5A5A, 4'd3, 16'h0000, 1'b1);  // R10

        // Random traffic
        for (int n = 0; n < 10; n++) begin
            case ($urandom % 3)
                0:       rsel = 4'd0;
                1:       rsel = 4'd2;
                default: rsel = 4'd3;
            endcase
            run_txn(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom), rsel,
                    16'($urandom), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule